// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the count-down timer of a per-core local interrupt controller. A bus-clock tick stream enters through a programmable prescaler. Each cycle the `bus_ticks` input reports how many bus-clock periods have passed, and the prescaler turns them into whole divided periods. The divided periods are subtracted from a current count. Software starts the timer by writing an initial count. When the remaining count is used up, the timer expires. On expiry it raises a one-cycle interrupt request that carries the vector programmed in its local vector table (LVT) entry. In periodic mode the timer then reloads and keeps running. In one-shot mode it parks at zero.

Register access uses a simple write port and a combinational read port, both indexed by a 4-bit register address. A software-enable input stands in for the enable bit of the spurious-vector register. While that input is low, every LVT write is stored with its mask bit set. The block holds six LVT entries so that this masking and the reset state can be seen on every entry. Only entry 0, the timer entry, affects the timer.

The control is a three-state machine:
- IDLE_OFF: the initial count is zero.
- COUNTING: the counter is decrementing.
- SPENT: a one-shot count has expired.

Its transitions are:
- LOAD_START: any state goes to COUNTING on a non-zero initial-count write.
- LOAD_STOP: any state goes to IDLE_OFF on a zero initial-count write.
- RELOAD: COUNTING stays in COUNTING on a periodic expiry.
- EXPIRE: COUNTING goes to SPENT on a one-shot expiry.

Top module: `lapic_timer`

## Requirements
- R1: After reset the initial count, the current count and the divide field read 0. Every LVT entry reads 0x00010000 (masked, vector 0, one-shot). `irq_valid` is low.
- R2: Only bits 3, 1 and 0 of a divide-register write are kept. Read-back shows them in place, with all other bits 0. The code {b3,b1,b0} selects the divisor: 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1.
- R3: Each cycle, the bus ticks are added to a prescaler remainder. The whole divided periods in the sum are the decrement. A write of the initial count (address 0) loads the current count with that value and restarts the prescaler. A write of the divide register also restarts the prescaler. The ticks of either write cycle are discarded. The current count is read at address 1.
- R4: An initial count of 0 leaves the current count at 0 and raises no interrupt, whatever ticks arrive.
- R5: In one-shot mode the timer expires when a cycle's decrement is at least the current count. It then holds 0 and raises no further request until the initial count is written again.
- R6: In periodic mode, an expiry reloads the count with the initial count minus the excess (the decrement minus the count). The reload is 0 if the excess is at least the initial count. The current count never exceeds the initial count.
- R7: The cycle after an expiry, `irq_valid` is high for one cycle, and `irq_vector` holds bits 7:0 of the timer LVT entry. This happens only if the entry's mask bit 16 was clear at the expiry; otherwise no request is raised.
- R8: An LVT write (addresses 8 to 13, entry 0 is the timer) made while `sw_enable` is low is stored with mask bit 16 forced to 1.
- R9: Writes to the current-count address (1) are ignored.
- R10: An LVT entry keeps the vector in bits 7:0, the mask in bit 16 and periodic mode in bit 17. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_enable | input | 1 | Software enable of the controller; low forces stored LVT entries masked |
| bus_ticks | input | 8 | Bus-clock periods elapsed in this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq_valid | output | 1 | One-cycle interrupt request on timer expiry |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
The assertions assume three things about the inputs:
- Software does not write the initial count and expect the count to keep moving in the same cycle. A write cycle discards its ticks, so a check on the current-count write holds only when `bus_ticks` is zero in that cycle.
- Read-only and load checks rely on single writes per cycle.
- Ticks are small enough that a decrement never reaches the count's width.

The stimulus does all register writes with zero ticks. It sweeps all eight divide codes, both modes and several initial counts under a varying tick pattern of up to 199 per cycle. All of these stay inside those bounds.

// File: rtl/lapic_tmr_pkg.sv
package lapic_tmr_pkg;

    // Timer control states
    typedef enum logic [1:0] {
        IDLE_OFF = 2'd0,
        COUNTING = 2'd1,
        SPENT    = 2'd2
    } tmr_state_e;

    // Stored part of one vector-table entry
    typedef struct packed {
        logic       periodic;
        logic       mask;
        logic [7:0] vector;
    } lvt_entry_t;

    // Field positions inside a 32-bit vector-table word
    localparam int LVT_MASK_BIT = 16;
    localparam int LVT_MODE_BIT = 17;

    // Largest prescaler shift (divide by 128)
    localparam int DIV_MAX_SHIFT = 7;

    // Register addresses
    localparam int ADDR_INIT     = 0;
    localparam int ADDR_CUR      = 1;
    localparam int ADDR_DIV      = 2;
    localparam int ADDR_LVT_BASE = 8;

    // Code {b3,b1,b0} -> log2 of the divisor; 111 means divide by one
    function automatic logic [2:0] div_shift(input logic [2:0] code);
        logic [2:0] sh;
        if (code == 3'b111) begin
            sh = 3'd0;
        end else begin
            sh = code + 3'd1;
        end
        return sh;
    endfunction

    function automatic lvt_entry_t lvt_from_word(input logic [31:0] w, input logic force_mask);
        lvt_entry_t e;
        e.vector   = w[7:0];
        e.mask     = w[LVT_MASK_BIT] | force_mask;
        e.periodic = w[LVT_MODE_BIT];
        return e;
    endfunction

    function automatic logic [31:0] lvt_to_word(input lvt_entry_t e);
        logic [31:0] w;
        w               = '0;
        w[7:0]          = e.vector;
        w[LVT_MASK_BIT] = e.mask;
        w[LVT_MODE_BIT] = e.periodic;
        return w;
    endfunction

endpackage

// File: rtl/lapic_tmr_prescale.sv
module lapic_tmr_prescale
    import lapic_tmr_pkg::*;
#(
    parameter int TICK_W = 8,
    parameter int DEC_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [2:0]        div_code,
    input  logic [TICK_W-1:0] ticks,
    output logic [DEC_W-1:0]  dec
);

    logic [DIV_MAX_SHIFT-1:0] frac_q;
    logic [DEC_W-1:0]         sum;
    logic [DEC_W-1:0]         low_mask;
    logic [2:0]               sh;

    // Remainder plus new ticks; the whole divided periods leave as the decrement
    always_comb begin
        sh       = div_shift(div_code);
        sum      = DEC_W'(frac_q) + DEC_W'(ticks);
        low_mask = (DEC_W'(1) << sh) - DEC_W'(1);
        if (restart) begin
            dec = '0;
        end else begin
            dec = sum >> sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (restart) begin
            frac_q <= '0;
        end else begin
            frac_q <= DIV_MAX_SHIFT'(sum & low_mask);
        end
    end

endmodule

// File: rtl/lapic_tmr_regs.sv
module lapic_tmr_regs
    import lapic_tmr_pkg::*;
#(
    parameter int NUM_LVT = 6,
    parameter int ADDR_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sw_enable,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [31:0]                   wr_data,
    output logic [2:0]                    div_code,
    output lvt_entry_t [NUM_LVT-1:0]      lvt_q
);

    localparam lvt_entry_t LVT_RESET = '{periodic: 1'b0, mask: 1'b1, vector: 8'h00};

    lvt_entry_t entry_q [NUM_LVT];

    // Divide field: only bits 3, 1 and 0 are kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_code <= 3'b000;
        end else if (wr_en && (wr_addr == ADDR_W'(ADDR_DIV))) begin
            div_code <= {wr_data[3], wr_data[1:0]};
        end
    end

    // One register per table entry; a disabled controller stores masked entries
    for (genvar i = 0; i < NUM_LVT; i++) begin : g_lvt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[i] <= LVT_RESET;
            end else if (wr_en && (wr_addr == ADDR_W'(ADDR_LVT_BASE + i))) begin
                entry_q[i] <= lvt_from_word(wr_data, !sw_enable);
            end
        end
        assign lvt_q[i] = entry_q[i];
    end

endmodule

// File: rtl/lapic_tmr_core.sv
module lapic_tmr_core
    import lapic_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DEC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [DEC_W-1:0] dec,
    input  logic             periodic,
    input  logic             mask,
    input  logic [7:0]       vector,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [CNT_W-1:0] init_cnt,
    output tmr_state_e       state,
    output logic             irq_valid,
    output logic [7:0]       irq_vector
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] init_q, init_d;
    logic [CNT_W-1:0] dec_w;
    logic [CNT_W-1:0] excess;
    logic             fire;

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        init_d  = init_q;
        fire    = 1'b0;
        dec_w   = CNT_W'(dec);
        excess  = '0;
        if (load) begin
            init_d = load_val;
            cnt_d  = load_val;
            if (load_val == '0) begin
                state_d = IDLE_OFF;   // LOAD_STOP
            end else begin
                state_d = COUNTING;   // LOAD_START
            end
        end else begin
            unique case (state_q)
                IDLE_OFF: begin
                    state_d = IDLE_OFF;
                end
                COUNTING: begin
                    if (dec_w != '0) begin
                        if (cnt_q > dec_w) begin
                            cnt_d = cnt_q - dec_w;
                        end else begin
                            fire   = 1'b1;
                            excess = dec_w - cnt_q;
                            if (periodic) begin
                                // RELOAD: carry the overshoot into the new period
                                if (excess < init_q) begin
                                    cnt_d = init_q - excess;
                                end else begin
                                    cnt_d = '0;
                                end
                                state_d = COUNTING;
                            end else begin
                                // EXPIRE
                                cnt_d   = '0;
                                state_d = SPENT;
                            end
                        end
                    end
                end
                SPENT: begin
                    state_d = SPENT;
                end
                default: begin
                    state_d = IDLE_OFF;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE_OFF;
            cnt_q   <= '0;
            init_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            init_q  <= init_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= 8'h00;
        end else begin
            irq_valid <= fire && !mask;
            if (fire) begin
                irq_vector <= vector;
            end
        end
    end

    assign cur_cnt  = cnt_q;
    assign init_cnt = init_q;
    assign state    = state_q;

endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
    import lapic_tmr_pkg::*;
#(
    parameter int TICK_W  = 8,
    parameter int CNT_W   = 32,
    parameter int NUM_LVT = 6,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_enable,
    input  logic [TICK_W-1:0] bus_ticks,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_valid,
    output logic [7:0]        irq_vector
);

    localparam int DEC_W = ((TICK_W > DIV_MAX_SHIFT) ? TICK_W : DIV_MAX_SHIFT) + 1;

    logic                     load;
    logic                     div_write;
    logic                     restart;
    logic [2:0]               div_code;
    logic [DEC_W-1:0]         dec;
    lvt_entry_t [NUM_LVT-1:0] lvt_q;
    logic                     timer_periodic;
    logic                     timer_mask;
    logic [7:0]               timer_vector;
    logic [CNT_W-1:0]         cur_cnt;
    logic [CNT_W-1:0]         init_cnt;
    tmr_state_e               tmr_state;

    assign load      = wr_en && (wr_addr == ADDR_W'(ADDR_INIT));
    assign div_write = wr_en && (wr_addr == ADDR_W'(ADDR_DIV));
    assign restart   = load || div_write;

    assign timer_periodic = lvt_q[0].periodic;
    assign timer_mask     = lvt_q[0].mask;
    assign timer_vector   = lvt_q[0].vector;

    lapic_tmr_regs #(
        .NUM_LVT (NUM_LVT),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_enable (sw_enable),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .div_code  (div_code),
        .lvt_q     (lvt_q)
    );

    lapic_tmr_prescale #(
        .TICK_W (TICK_W),
        .DEC_W  (DEC_W)
    ) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .div_code (div_code),
        .ticks    (bus_ticks),
        .dec      (dec)
    );

    lapic_tmr_core #(
        .CNT_W (CNT_W),
        .DEC_W (DEC_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (CNT_W'(wr_data)),
        .dec        (dec),
        .periodic   (timer_periodic),
        .mask       (timer_mask),
        .vector     (timer_vector),
        .cur_cnt    (cur_cnt),
        .init_cnt   (init_cnt),
        .state      (tmr_state),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_INIT)) begin
            rd_data = 32'(init_cnt);
        end else if (rd_addr == ADDR_W'(ADDR_CUR)) begin
            rd_data = 32'(cur_cnt);
        end else if (rd_addr == ADDR_W'(ADDR_DIV)) begin
            rd_data = {28'h0, div_code[2], 1'b0, div_code[1:0]};
        end else begin
            for (int i = 0; i < NUM_LVT; i++) begin
                if (rd_addr == ADDR_W'(ADDR_LVT_BASE + i)) begin
                    rd_data = lvt_to_word(lvt_q[i]);
                end
            end
        end
    end

endmodule

// File: rtl/lapic_timer_chk.sv
module lapic_timer_chk #(
    parameter int TICK_W = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_enable,
    input logic [TICK_W-1:0] bus_ticks,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq_valid,
    input logic [7:0]        irq_vector,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [CNT_W-1:0]  init_cnt,
    input logic              t_periodic,
    input logic              t_mask,
    input logic [7:0]        t_vector
);

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(0)) |=> (cur_cnt == init_cnt)); // R3

    AST_ZERO_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (init_cnt == '0) |-> !irq_valid); // R4

    AST_ONESHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !$past(t_periodic)) |=> !irq_valid); // R5

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cur_cnt <= init_cnt); // R6

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector == $past(t_vector))); // R7

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(t_mask)); // R7

    AST_DISABLED_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(8) && !sw_enable) |=> t_mask); // R8

    AST_CUR_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(1) && bus_ticks == '0) |=> $stable(cur_cnt)); // R9

endmodule

bind lapic_timer lapic_timer_chk #(
    .TICK_W (TICK_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_enable  (sw_enable),
    .bus_ticks  (bus_ticks),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .cur_cnt    (cur_cnt),
    .init_cnt   (init_cnt),
    .t_periodic (timer_periodic),
    .t_mask     (timer_mask),
    .t_vector   (timer_vector)
);

// File: tb/lapic_timer_test.sv
module lapic_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_enable = 1'b0;
    logic [7:0]  bus_ticks = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    always #5 clk = ~clk;

    lapic_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_enable  (sw_enable),
        .bus_ticks  (bus_ticks),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    logic [31:0] m_icr, m_ccr;
    int          m_presc;
    int          m_state;        // 0 off, 1 counting, 2 spent
    logic [2:0]  m_code;
    logic [31:0] m_lvt [6];
    bit          e_irq;
    logic [7:0]  e_vec;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_icr = 0; m_ccr = 0; m_presc = 0; m_state = 0; m_code = 3'b000;
        for (int i = 0; i < 6; i++) m_lvt[i] = 32'h0001_0000;
        e_irq = 0; e_vec = 0;
    endtask

    task automatic model_step(input bit we, input logic [3:0] a, input logic [31:0] d, input int el);
        int          sh, sum;
        logic [31:0] dd, ex;
        e_irq = 0;
        if (we && (a == 4'd0 || a == 4'd2)) begin
            if (a == 4'd0) begin
                m_icr = d; m_ccr = d; m_state = (d == 0) ? 0 : 1;
            end else begin
                m_code = {d[3], d[1], d[0]};
            end
            m_presc = 0;
        end else begin
            sh  = (m_code == 3'b111) ? 0 : int'(m_code) + 1;
            sum = m_presc + el;
            dd  = 32'(sum >> sh);
            m_presc = sum % (1 << sh);
            if (m_state == 1 && dd != 0) begin
                if (m_ccr > dd) begin
                    m_ccr = m_ccr - dd;
                end else begin
                    ex = dd - m_ccr;
                    if (!m_lvt[0][16]) begin
                        e_irq = 1; e_vec = m_lvt[0][7:0];
                    end
                    if (m_lvt[0][17]) begin
                        m_ccr = (ex < m_icr) ? m_icr - ex : 32'd0;
                    end else begin
                        m_ccr = 0; m_state = 2;
                    end
                end
            end
            if (we && a >= 4'd8 && a < 4'd14)
                m_lvt[a - 8] = {14'h0, d[17], (sw_enable ? d[16] : 1'b1), 8'h00, d[7:0]};
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // One clock cycle: drive at the falling edge, check at the next falling edge
    task automatic cyc(input bit we, input logic [3:0] a, input logic [31:0] d, input int el, input string tag);
        logic [31:0] v;
        wr_en = we; wr_addr = a; wr_data = d; bus_ticks = 8'(el);
        model_step(we, a, d, el);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; bus_ticks = 0;
        rd(4'd1, v);
        chk(tag, "current count", v, m_ccr);
        chk("R7", "irq_valid", 32'(irq_valid), 32'(e_irq));
        if (e_irq) chk("R7", "irq_vector", 32'(irq_vector), 32'(e_vec));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int icr_set [3] = '{1, 5, 40};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v); chk("R1", "initial count", v, 0);
        rd(4'd1, v); chk("R1", "current count", v, 0);
        rd(4'd2, v); chk("R1", "divide", v, 0);
        for (int i = 0; i < 6; i++) begin
            rd(4'(8 + i), v); chk("R1", "lvt reset", v, 32'h0001_0000);
        end
        chk("R1", "irq_valid", 32'(irq_valid), 0);

        // R8 writes while disabled are stored masked
        sw_enable = 0;
        cyc(1, 4'd8, 32'h0002_0041, 0, "R8");
        rd(4'd8, v); chk("R8", "timer lvt forced mask", v, 32'h0003_0041);
        cyc(1, 4'd11, 32'hFFFF_FFFF, 0, "R8");
        rd(4'd11, v); chk("R8", "lvt3 forced mask", v, 32'h0003_00FF);

        // R10 field layout
        sw_enable = 1;
        cyc(1, 4'd11, 32'hFFFC_FF22, 0, "R10");
        rd(4'd11, v); chk("R10", "lvt3 fields", v, 32'h0000_0022);
        cyc(1, 4'd12, 32'h5A02_3399, 0, "R10");
        rd(4'd12, v); chk("R10", "lvt4 fields", v, 32'h0002_0099);

        // R2 divide field bits
        cyc(1, 4'd2, 32'hFFFF_FFF4, 0, "R2");
        rd(4'd2, v); chk("R2", "divide ignores bit2", v, 0);
        cyc(1, 4'd2, 32'h0000_000B, 0, "R2");
        rd(4'd2, v); chk("R2", "divide 111", v, 32'h0B);

        // R3 load and decrement at divide by one; ticks of the write cycle discarded
        cyc(1, 4'd8, 32'h0000_0050, 0, "R3");
        cyc(1, 4'd0, 32'd100, 50, "R3");
        rd(4'd1, v); chk("R3", "load value", v, 32'd100);
        cyc(0, 4'd0, 0, 30, "R3");
        rd(4'd1, v); chk("R3", "after 30 ticks", v, 32'd70);

        // R9 current count is read-only
        cyc(1, 4'd1, 32'h0000_1234, 0, "R9");
        rd(4'd1, v); chk("R9", "write to current ignored", v, 32'd70);

        // Sweep over divide codes, modes and initial counts
        for (int code = 0; code < 8; code++) begin
            logic [2:0] c3;
            c3 = 3'(code);
            cyc(1, 4'd2, {16'hA5A5, 12'h0, c3[2], 1'b1, c3[1:0]}, 0, "R2");
            rd(4'd2, v); chk("R2", "divide readback", v, {28'h0, c3[2], 1'b0, c3[1:0]});
            for (int per = 0; per < 2; per++) begin
                cyc(1, 4'd8, {14'h0, 1'(per), 1'b0, 8'h00, 8'(8'h30 + code * 2 + per)}, 0, "R10");
                for (int n = 0; n < 3; n++) begin
                    cyc(1, 4'd0, 32'(icr_set[n]), 0, "R3");
                    for (int k = 0; k < 40; k++)
                        cyc(0, 4'd0, 0, (k * 53 + icr_set[n] * 3 + code * 7) % 200,
                            (per != 0) ? "R6" : "R5");
                end
            end
        end

        // R4 zero initial count disables
        cyc(1, 4'd0, 32'd0, 0, "R4");
        for (int k = 0; k < 10; k++) cyc(0, 4'd0, 0, 90, "R4");
        rd(4'd1, v); chk("R4", "stays zero", v, 0);

        // R6 excess at least the initial count reloads zero (divide by one)
        cyc(1, 4'd2, 32'h0B, 0, "R6");
        cyc(1, 4'd8, 32'h0002_0077, 0, "R6");
        cyc(1, 4'd0, 32'd4, 0, "R6");
        cyc(0, 4'd0, 0, 9, "R6");
        rd(4'd1, v); chk("R6", "reload clamps to zero", v, 0);
        cyc(0, 4'd0, 0, 3, "R6");
        cyc(1, 4'd0, 32'd10, 0, "R6");
        cyc(0, 4'd0, 0, 13, "R6");
        rd(4'd1, v); chk("R6", "reload minus excess", v, 32'd7);

        // R7 masked timer entry raises nothing
        cyc(1, 4'd8, 32'h0003_0066, 0, "R7");
        for (int k = 0; k < 12; k++) cyc(0, 4'd0, 0, 6, "R7");

        // R5 one-shot: one request, then idle at zero
        cyc(1, 4'd8, 32'h0000_0021, 0, "R5");
        cyc(1, 4'd0, 32'd5, 0, "R5");
        cyc(0, 4'd0, 0, 5, "R5");
        for (int k = 0; k < 8; k++) cyc(0, 4'd0, 0, 200, "R5");
        rd(4'd1, v); chk("R5", "one-shot parked", v, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule